// File: doc/BRIEF.md
# Dynamic Voltage-Code Reference Slewer

This block tracks the 5-bit voltage-identification code that a processor presents to its supply regulator. It holds the regulator's internal reference setpoint as a code in 25 mV units. When the requested code changes, the block moves that setpoint toward the new value in single 25 mV steps, so the output voltage follows a controlled ramp instead of jumping. A one-clock pulse marks the start of every phase-1 switching cycle. The requested code is looked at only on those pulses. A new code has to stay unchanged across one whole switching cycle before it becomes the target.

Two cooperating state machines do the work. A qualifier (`Q_BOOT`, `Q_WATCH`, `Q_CONFIRM`) samples and validates the requested code. A sequencer (`S_BOOT`, `S_SETTLED`, `S_HOLD`, `S_STEP`, `S_OFF`) paces the reference. The qualifier takes these transitions:
- Boot load: `Q_BOOT`→`Q_WATCH`.
- Mismatch seen: `Q_WATCH`→`Q_CONFIRM`.
- Confirm: `Q_CONFIRM`→`Q_WATCH`, the code is accepted.
- Revert: `Q_CONFIRM`→`Q_WATCH`, the code went back to the current target.
- Restart: `Q_CONFIRM`→`Q_CONFIRM`, another code was seen and a new check begins.

The sequencer takes these transitions:
- Boot: `S_BOOT`→`S_SETTLED`, or `S_BOOT`→`S_OFF` when the code at boot is all ones.
- Step that still leaves a gap: the acceptance pulse or `S_STEP`, to `S_HOLD`.
- Step that lands on the target: to `S_SETTLED`.
- Pacing: `S_HOLD`→`S_STEP`.
- Shutdown accepted: any state to `S_OFF`.
- Leaving shutdown: an accepted voltage code moves `S_OFF` to `S_HOLD` or `S_SETTLED`.

Top module: `vref_slew_ctrl`

## Requirements
- R1: On the first clock after reset is released, the reference loads the code present on `vid_in` directly, with no stepping. After that load, `busy` is 0, and `shutdown` is 1 only if the loaded code is 11111.
- R2: `vid_in` is sampled only on clocks where `cyc_start` is 1. A change that reverts before the next pulse has no effect on any output.
- R3: Suppose a code sampled on a pulse differs from the current target. It becomes the target on the next pulse, but only if that pulse samples the same code. `busy` stays 0 until then.
- R4: Suppose the confirming pulse samples a different code. The pending code is then discarded. If the sample equals the current target, nothing happens. Otherwise the new sample starts a fresh one-pulse check.
- R5: The reference changes only on `cyc_start` pulses, and only by one code unit. The first step happens on the acceptance pulse. Later steps happen on every second pulse until the reference equals the target.
- R6: The code encoding is as follows. 11010 is 0.900 V, 11011 is 0.875 V, 11100 is 0.850 V, 11101 is 0.825 V and 11110 is 0.800 V. Each code increment lowers the voltage by 25 mV. Steps go in whichever direction closes the gap, either up or down in code.
- R7: `busy` is 1 from the acceptance pulse until the pulse on which the reference reaches the target. It is 0 otherwise.
- R8: Assume a pulse every P clocks. A 200 mV change toward higher voltage (8 steps, for example 01110 to 00110) completes between 15·P and 16·P clocks after `vid_in` changes.
- R9: A code accepted during a ramp replaces the target. Stepping continues from the present reference, with no jump. When the acceptance pulse is also a scheduled step pulse, exactly one step is taken, and it goes toward the new target.
- R10: When 11111 is accepted, `shutdown` goes to 1, `busy` goes to 0 and the reference is frozen. A later accepted voltage code clears `shutdown` and ramps from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse at the start of each phase-1 switching cycle |
| vid_in | input | 5 | Raw requested voltage code |
| ref_code | output | 5 | Current reference code in 25 mV units |
| busy | output | 1 | A transition is in progress |
| shutdown | output | 1 | The shutdown code has been accepted |

## Verification
Two functions can fall on the same pulse. One is the qualifier accepting a new target. The other is the sequencer's scheduled step in `S_STEP`. The bench provokes this during a ramp by changing `vid_in` right after a step pulse. Confirmation then lands exactly two pulses later, which is the next scheduled step. The scoreboard expects exactly one step on that pulse, toward the new target, followed by settling with `busy` low and no further step. A second coincidence, between a code that reverts and the confirming pulse, is judged by the absence of any step and by `busy` staying low.

// File: rtl/vref_pkg.sv
package vref_pkg;

    // Qualifier: watches the requested code and validates changes.
    typedef enum logic [1:0] {
        Q_BOOT    = 2'd0,
        Q_WATCH   = 2'd1,
        Q_CONFIRM = 2'd2
    } qual_state_t;

    // Sequencer: paces the reference toward the target.
    typedef enum logic [2:0] {
        S_BOOT    = 3'd0,
        S_SETTLED = 3'd1,
        S_HOLD    = 3'd2,
        S_STEP    = 3'd3,
        S_OFF     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/vref_step_unit.sv
// Combinational one-unit move of the reference toward a goal code.
module vref_step_unit #(
    parameter int W = 5
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] goal,
    output logic [W-1:0] nxt,
    output logic         at_goal,
    output logic         lands
);
    logic go_up;

    always_comb begin
        at_goal = (cur == goal);
        go_up   = (goal > cur);
        if (at_goal)
            nxt = cur;
        else if (go_up)
            nxt = cur + 1'b1;
        else
            nxt = cur - 1'b1;
        lands = (nxt == goal);
    end
endmodule

// File: rtl/vref_qualifier.sv
// Samples the requested code on cycle-start pulses and validates it
// across one full switching cycle before releasing it as the target.
module vref_qualifier
    import vref_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_start,
    input  logic [W-1:0] vid_in,
    output logic         boot_load,
    output logic         accept,
    output logic [W-1:0] goal,
    output logic [W-1:0] target_q
);
    qual_state_t  state, state_n;
    logic [W-1:0] pend, pend_n;
    logic [W-1:0] tgt, tgt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_BOOT;
            pend  <= '0;
            tgt   <= '0;
        end else begin
            state <= state_n;
            pend  <= pend_n;
            tgt   <= tgt_n;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n   = state;
        pend_n    = pend;
        tgt_n     = tgt;
        accept    = 1'b0;
        boot_load = 1'b0;
        unique case (state)
            Q_BOOT: begin
                boot_load = 1'b1;
                tgt_n     = vid_in;
                state_n   = Q_WATCH;
            end
            Q_WATCH: begin
                if (cyc_start && (vid_in != tgt)) begin
                    pend_n  = vid_in;
                    state_n = Q_CONFIRM;
                end
            end
            Q_CONFIRM: begin
                if (cyc_start) begin
                    if (vid_in == pend) begin
                        accept  = 1'b1;
                        tgt_n   = pend;
                        state_n = Q_WATCH;
                    end else if (vid_in == tgt) begin
                        state_n = Q_WATCH;
                    end else begin
                        pend_n  = vid_in;
                    end
                end
            end
            default: state_n = Q_BOOT;
        endcase
        goal     = accept ? pend : tgt;
        target_q = tgt;
    end
endmodule

// File: rtl/vref_sequencer.sv
// Holds the reference and steps it once per two cycle-start pulses.
module vref_sequencer
    import vref_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_start,
    input  logic         boot_load,
    input  logic [W-1:0] boot_code,
    input  logic         accept,
    input  logic [W-1:0] goal,
    input  logic [W-1:0] step_code,
    input  logic         at_goal,
    input  logic         lands,
    output logic [W-1:0] ref_q,
    output logic         busy,
    output logic         shutdown
);
    localparam logic [W-1:0] SHUT_CODE = {W{1'b1}};

    seq_state_t   state, state_n;
    logic [W-1:0] ref_r, ref_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_BOOT;
            ref_r <= '0;
        end else begin
            state <= state_n;
            ref_r <= ref_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        ref_n   = ref_r;
        if (state == S_BOOT) begin
            if (boot_load) begin
                ref_n   = boot_code;
                state_n = (boot_code == SHUT_CODE) ? S_OFF : S_SETTLED;
            end
        end else if (cyc_start && accept) begin
            if (goal == SHUT_CODE) begin
                state_n = S_OFF;
            end else if (at_goal) begin
                state_n = S_SETTLED;
            end else begin
                ref_n   = step_code;
                state_n = lands ? S_SETTLED : S_HOLD;
            end
        end else if (cyc_start) begin
            unique case (state)
                S_HOLD: state_n = S_STEP;
                S_STEP: begin
                    ref_n   = step_code;
                    state_n = lands ? S_SETTLED : S_HOLD;
                end
                S_SETTLED, S_OFF: state_n = state;
                default: state_n = S_BOOT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ref_q    = ref_r;
        busy     = (state == S_HOLD) || (state == S_STEP);
        shutdown = (state == S_OFF);
    end
endmodule

// File: rtl/vref_slew_ctrl.sv
module vref_slew_ctrl #(
    parameter int VID_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [VID_W-1:0] vid_in,
    output logic [VID_W-1:0] ref_code,
    output logic             busy,
    output logic             shutdown
);
    logic             boot_load;
    logic             accept;
    logic [VID_W-1:0] goal;
    logic [VID_W-1:0] target_code;
    logic [VID_W-1:0] step_code;
    logic             at_goal;
    logic             lands;

    vref_qualifier #(.W(VID_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .vid_in    (vid_in),
        .boot_load (boot_load),
        .accept    (accept),
        .goal      (goal),
        .target_q  (target_code)
    );

    vref_step_unit #(.W(VID_W)) u_step (
        .cur     (ref_code),
        .goal    (goal),
        .nxt     (step_code),
        .at_goal (at_goal),
        .lands   (lands)
    );

    vref_sequencer #(.W(VID_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .boot_load (boot_load),
        .boot_code (vid_in),
        .accept    (accept),
        .goal      (goal),
        .step_code (step_code),
        .at_goal   (at_goal),
        .lands     (lands),
        .ref_q     (ref_code),
        .busy      (busy),
        .shutdown  (shutdown)
    );
endmodule

// File: rtl/vref_slew_chk.sv
module vref_slew_chk #(
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_start,
    input logic [W-1:0] ref_code,
    input logic         busy,
    input logic         shutdown,
    input logic [W-1:0] target_code
);
    // Clocks since reset, saturating; boot load happens on the first.
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    assert_step_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$stable(ref_code)) |-> $past(cyc_start));

    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$stable(ref_code)) |->
            ((ref_code == $past(ref_code) + 1'b1) || (ref_code == $past(ref_code) - 1'b1)));

    assert_busy_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && busy) |-> (ref_code != target_code));

    assert_settle_on_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $fell(busy) && !shutdown) |-> (ref_code == target_code));

    assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !busy);

    assert_off_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && shutdown && $past(shutdown)) |-> $stable(ref_code));
endmodule

bind vref_slew_ctrl vref_slew_chk #(.W(VID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .ref_code    (ref_code),
    .busy        (busy),
    .shutdown    (shutdown),
    .target_code (target_code)
);

// File: tb/test_vref_slew_ctrl.sv
`timescale 1ns/1ps
module test_vref_slew_ctrl;
    localparam int W   = 5;
    localparam int PER = 10;   // clocks per switching cycle

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc_start = 1'b0;
    logic [W-1:0] vid_in = 5'b01110;
    logic [W-1:0] ref_code;
    logic         busy;
    logic         shutdown;

    int checks = 0;
    int fails  = 0;
    int pcount = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int           pulse;
        logic [W-1:0] code;
        string        tag;
    } exp_t;
    exp_t sbq[$];

    vref_slew_ctrl #(.VID_W(W)) i_vref_slew_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .vid_in    (vid_in),
        .ref_code  (ref_code),
        .busy      (busy),
        .shutdown  (shutdown)
    );

    always #5 clk = ~clk;

    // Cycle-start pulse generator, updated 2 ns after each rising edge.
    initial begin : pulse_gen
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            if (cyc_start) pcount++;
            #2;
            ph = (ph == PER-1) ? 0 : ph + 1;
            cyc_start = (ph == PER-1);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_until(input int p);
        while (pcount < p) @(negedge clk);
    endtask

    // Driver helper: schedule a ramp of codes, one per two pulses.
    task automatic push_ramp(input logic [W-1:0] from, input logic [W-1:0] to,
                             input int first_pulse, input string tag);
        logic [W-1:0] c;
        int p;
        c = from;
        p = first_pulse;
        while (c != to) begin
            c = (to > c) ? c + 1'b1 : c - 1'b1;
            sbq.push_back('{p, c, tag});
            p += 2;
        end
    endtask

    // Monitor: every reference change must match the head of the queue.
    initial begin : monitor
        logic [W-1:0] prev;
        exp_t e;
        prev = '0;
        forever begin
            @(negedge clk);
            if (!mon_en) begin
                prev = ref_code;
            end else if (ref_code != prev) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R5 unexpected step", int'(ref_code), int'(prev));
                end else begin
                    e = sbq.pop_front();
                    check(ref_code == e.code, {e.tag, " step value"}, int'(ref_code), int'(e.code));
                    check(pcount == e.pulse, {e.tag, " step pulse"}, pcount, e.pulse);
                end
                prev = ref_code;
            end
        end
    end

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", pcount);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        int k;
        int elapsed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: direct load at boot
        check(ref_code == 5'b01110, "R1 boot ref", int'(ref_code), 14);
        check(busy == 1'b0, "R1 boot busy", int'(busy), 0);
        check(shutdown == 1'b0, "R1 boot shutdown", int'(shutdown), 0);
        mon_en = 1'b1;

        // R2: change between pulses that reverts before the next pulse
        k = pcount + 1;
        wait_until(k);
        vid_in = 5'b00000;
        repeat (3) @(negedge clk);
        vid_in = 5'b01110;
        wait_until(k + 3);
        check(ref_code == 5'b01110 && !busy, "R2 unsampled glitch", int'(ref_code), 14);

        // R4: sampled once, then back to target before confirmation
        k = pcount;
        vid_in = 5'b01000;
        wait_until(k + 1);
        vid_in = 5'b01110;
        wait_until(k + 4);
        check(ref_code == 5'b01110 && !busy, "R4 reverted code ignored", int'(ref_code), 14);

        // R4/R3: sampled code changes during its check -> fresh validation
        k = pcount;
        vid_in = 5'b01000;
        wait_until(k + 1);
        vid_in = 5'b01010;
        push_ramp(5'b01110, 5'b01010, k + 3, "R4 fresh validation");
        wait_until(k + 2);
        check(busy == 1'b0, "R3 busy before confirm", int'(busy), 0);
        wait_until(k + 3);
        check(busy == 1'b1, "R7 busy at acceptance", int'(busy), 1);
        wait_until(k + 9);
        check(ref_code == 5'b01010 && !busy, "R7 settled low", int'(busy), 0);

        // R6: downward-voltage ramp (code rises)
        k = pcount;
        vid_in = 5'b01101;
        push_ramp(5'b01010, 5'b01101, k + 2, "R6 code-up ramp");
        wait_until(k + 6);
        check(ref_code == 5'b01101, "R6 reached", int'(ref_code), 13);
        k = pcount;
        vid_in = 5'b01110;
        push_ramp(5'b01101, 5'b01110, k + 2, "R6 single step");
        wait_until(k + 3);

        // R8 case A: change right after a pulse -> 16 cycles
        k = pcount;
        vid_in = 5'b00110;
        push_ramp(5'b01110, 5'b00110, k + 2, "R8 ramp A");
        elapsed = 0;
        do begin
            @(posedge clk);
            elapsed++;
            @(negedge clk);
        end while (ref_code != 5'b00110 && elapsed < 40 * PER);
        check(elapsed == 16 * PER, "R8 late change time", elapsed, 16 * PER);
        check(elapsed >= 15 * PER && elapsed <= 16 * PER, "R8 window A", elapsed, 16 * PER);
        check(busy == 1'b0, "R7 idle after ramp A", int'(busy), 0);

        k = pcount;
        vid_in = 5'b01110;
        push_ramp(5'b00110, 5'b01110, k + 2, "R6 ramp back");
        wait_until(k + 17);

        // R8 case B: change just before a pulse -> 15 cycles plus one clock
        k = pcount;
        repeat (PER - 1) @(negedge clk);
        vid_in = 5'b00110;
        push_ramp(5'b01110, 5'b00110, k + 2, "R8 ramp B");
        elapsed = 0;
        do begin
            @(posedge clk);
            elapsed++;
            @(negedge clk);
        end while (ref_code != 5'b00110 && elapsed < 40 * PER);
        check(elapsed >= 15 * PER && elapsed <= 16 * PER, "R8 window B", elapsed, 15 * PER + 1);
        wait_until(pcount + 1);

        // R9: retarget mid-ramp, acceptance coincides with scheduled step
        k = pcount;
        vid_in = 5'b01110;
        sbq.push_back('{k + 2, 5'b00111, "R9 ramp"});
        sbq.push_back('{k + 4, 5'b01000, "R9 ramp"});
        sbq.push_back('{k + 6, 5'b01001, "R9 ramp"});
        sbq.push_back('{k + 8, 5'b01000, "R9 coincident retarget"});
        wait_until(k + 6);
        vid_in = 5'b01000;
        wait_until(k + 8);
        check(busy == 1'b0, "R9 settled after one step", int'(busy), 0);
        wait_until(k + 12);
        check(ref_code == 5'b01000, "R9 no further step", int'(ref_code), 8);

        // R10: shutdown freezes reference, later code resumes from it
        k = pcount;
        vid_in = 5'b11111;
        wait_until(k + 1);
        check(shutdown == 1'b0, "R10 not before validation", int'(shutdown), 0);
        wait_until(k + 2);
        check(shutdown == 1'b1 && !busy, "R10 shutdown accepted", int'(shutdown), 1);
        wait_until(k + 5);
        check(ref_code == 5'b01000, "R10 frozen ref", int'(ref_code), 8);
        k = pcount;
        vid_in = 5'b00111;
        push_ramp(5'b01000, 5'b00111, k + 2, "R10 resume");
        wait_until(k + 2);
        check(shutdown == 1'b0 && ref_code == 5'b00111, "R10 leave shutdown", int'(ref_code), 7);
        wait_until(k + 4);

        check(sbq.size() == 0, "R5 all scheduled steps seen", sbq.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule